// File: doc/BRIEF.md
# Test-and-Test-and-Set Lock Acquirer with Doubling Backoff

This block acquires one shared lock bit for a single client. The bit lives in an atomic lock register. The block reaches that register through a request channel that uses valid/ready and a response channel that carries only valid. The client holds `acquire_i` high until `granted_o` rises. While it owns the lock it leaves `granted_o` high, and it gives the lock back with a one-cycle pulse on `release_i`.

To keep traffic on the shared register low, the engine first polls the bit with plain reads. It sends the atomic test-and-set only after a read has shown the bit as clear. If the test-and-set finds the bit already set, the engine stays off the port for a pause. The pause starts at `min_delay_i` and doubles after every further failure, up to a ceiling of `max_delay_i`. Release is an ordinary write of zero to the bit.

Request port rules. A request is taken on a cycle where `lk_req_valid_o` and `lk_req_ready_i` are both high. Once the engine raises valid, it keeps valid and the op code unchanged until ready is seen. A read or a test-and-set is answered by exactly one `lk_rsp_valid_i` pulse, which may arrive any number of cycles after the handshake. A clear gets no response. The response channel cannot be stalled.

Top module: `tas_lock_requester`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `granted_o` and `lk_req_valid_o` are low.
- R2: When an acquisition starts from idle, the first request sent is a read (op code 0). A test-and-set (op code 1) is sent only after a read response that returned 0.
- R3: When a read response returns 1, the next request is another read. While the bit stays set, the engine sends no test-and-set and `granted_o` stays low.
- R4: When a test-and-set response returns 0, `granted_o` rises on the next cycle. It stays high until a release pulse arrives.
- R5: When a test-and-set response returns 1, the engine sends no request for exactly the current delay, counted in cycles. It then sends a read. From the failing response to the next valid request there are delay+1 cycles.
- R6: After each failed test-and-set, the delay becomes the smaller of twice the old delay and `max_delay_i`.
- R7: Each acquisition starts with its delay at `min_delay_i`, or at 1 if that input is 0. This holds both after reset and after an earlier successful acquisition.
- R8: While `lk_req_valid_o` is high and `lk_req_ready_i` is low, valid and `lk_req_op_o` do not change on the next cycle.
- R9: A release pulse while the lock is held produces exactly one clear request (op code 2). After that request is accepted, `granted_o` is low and the engine is idle.
- R10: When several engines share one lock register, at most one of them shows `granted_o` high in any cycle. Every engine that keeps requesting eventually gets the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acquire_i | input | 1 | Client wants the lock; sampled only while idle |
| release_i | input | 1 | One-cycle pulse that hands the lock back; used only while held |
| granted_o | output | 1 | Lock is owned by this client |
| min_delay_i | input | DLY_W | Starting backoff delay in cycles |
| max_delay_i | input | DLY_W | Ceiling for the backoff delay |
| lk_req_valid_o | output | 1 | Request to the lock register is valid |
| lk_req_ready_i | input | 1 | Lock register accepts the request |
| lk_req_op_o | output | 2 | 0 read, 1 test-and-set, 2 clear |
| lk_rsp_valid_i | input | 1 | Response for a read or test-and-set |
| lk_rsp_flag_i | input | 1 | Bit value returned (old value for a test-and-set) |

## Verification
The bench keeps the default delay width of 8 bits and builds three engines. They share one lock register model whose fixed priority gives lower indices the win. Because of the 8-bit width, ceilings of 255 can be reached, and a ceiling equal to the minimum gives a flat delay sequence. The model can be told to make a number of test-and-set operations fail. This forces chains of failures, so the delay doubling and its saturation can be seen from the port timing. With three engines, both port back-pressure and lock hand-over under contention can be exercised.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_TAS   = 2'd1,
    OP_CLEAR = 2'd2
  } lock_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_TAS_REQ,
    ST_TAS_WAIT,
    ST_PAUSE,
    ST_HELD,
    ST_CLR_REQ
  } eng_state_e;
endpackage

// File: rtl/tas_backoff.sv
module tas_backoff #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             fail_i,
  input  logic [DLY_W-1:0] min_i,
  input  logic [DLY_W-1:0] max_i,
  output logic             expire_o
);
  localparam int WIDE = DLY_W + 1;
  localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

  logic [DLY_W-1:0] cur_q, cnt_q, eff_min, next_dly;
  logic [WIDE-1:0]  doubled;

  always_comb begin
    eff_min  = (min_i == '0) ? ONE : min_i;
    doubled  = {cur_q, 1'b0};
    next_dly = (doubled > {1'b0, max_i}) ? max_i : doubled[DLY_W-1:0];
    expire_o = (cnt_q == ONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= ONE;
      cnt_q <= '0;
    end else if (start_i) begin
      cur_q <= eff_min;
      cnt_q <= '0;
    end else if (fail_i) begin
      cnt_q <= cur_q;
      cur_q <= next_dly;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && !start_i && (max_i >= cur_q)) |=> (cur_q <= $past(max_i)));

  assert_pause_loaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_i && !start_i) |=> (cnt_q != '0));
endmodule

// File: rtl/tas_fsm.sv
module tas_fsm
  import tas_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acquire_i,
  input  logic       release_i,
  input  logic       lk_req_ready_i,
  input  logic       lk_rsp_valid_i,
  input  logic       lk_rsp_flag_i,
  input  logic       expire_i,
  output logic       start_o,
  output logic       fail_o,
  output logic       granted_o,
  output logic       lk_req_valid_o,
  output logic [1:0] lk_req_op_o
);
  eng_state_e state_q, state_d;
  lock_op_e   op;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    fail_o  = 1'b0;
    unique case (state_q)
      ST_IDLE:     if (acquire_i) begin state_d = ST_RD_REQ; start_o = 1'b1; end
      ST_RD_REQ:   if (lk_req_ready_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (lk_rsp_valid_i) state_d = lk_rsp_flag_i ? ST_RD_REQ : ST_TAS_REQ;
      ST_TAS_REQ:  if (lk_req_ready_i) state_d = ST_TAS_WAIT;
      ST_TAS_WAIT: if (lk_rsp_valid_i) begin
                     if (lk_rsp_flag_i) begin state_d = ST_PAUSE; fail_o = 1'b1; end
                     else begin state_d = ST_HELD; start_o = 1'b1; end
                   end
      ST_PAUSE:    if (expire_i) state_d = ST_RD_REQ;
      ST_HELD:     if (release_i) state_d = ST_CLR_REQ;
      ST_CLR_REQ:  if (lk_req_ready_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_TAS_REQ: op = OP_TAS;
      ST_CLR_REQ: op = OP_CLEAR;
      default:    op = OP_READ;
    endcase
    lk_req_op_o    = op;
    lk_req_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_TAS_REQ) || (state_q == ST_CLR_REQ);
    granted_o      = (state_q == ST_HELD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req_valid_o && !lk_req_ready_i) |=> (lk_req_valid_o && $stable(lk_req_op_o)));

  assert_grant_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (granted_o && !release_i) |=> granted_o);

  assert_busy_reread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_WAIT && lk_rsp_valid_i && lk_rsp_flag_i)
      |=> (lk_req_valid_o && lk_req_op_o == OP_READ && !granted_o));

  assert_release_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (granted_o && release_i) |=> (lk_req_valid_o && lk_req_op_o == OP_CLEAR && !granted_o));

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && acquire_i) |=> (lk_req_valid_o && lk_req_op_o == OP_READ));

  assert_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!granted_o && !lk_req_valid_o));
endmodule

// File: rtl/tas_lock_requester.sv
module tas_lock_requester #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acquire_i,
  input  logic             release_i,
  output logic             granted_o,
  input  logic [DLY_W-1:0] min_delay_i,
  input  logic [DLY_W-1:0] max_delay_i,
  output logic             lk_req_valid_o,
  input  logic             lk_req_ready_i,
  output logic [1:0]       lk_req_op_o,
  input  logic             lk_rsp_valid_i,
  input  logic             lk_rsp_flag_i
);
  logic start_w, fail_w, expire_w;

  tas_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .acquire_i      (acquire_i),
    .release_i      (release_i),
    .lk_req_ready_i (lk_req_ready_i),
    .lk_rsp_valid_i (lk_rsp_valid_i),
    .lk_rsp_flag_i  (lk_rsp_flag_i),
    .expire_i       (expire_w),
    .start_o        (start_w),
    .fail_o         (fail_w),
    .granted_o      (granted_o),
    .lk_req_valid_o (lk_req_valid_o),
    .lk_req_op_o    (lk_req_op_o)
  );

  tas_backoff #(.DLY_W(DLY_W)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_w),
    .fail_i   (fail_w),
    .min_i    (min_delay_i),
    .max_i    (max_delay_i),
    .expire_o (expire_w)
  );

  assert_pause_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_w |=> !lk_req_valid_o);
endmodule

// File: tb/sim_tas_lock_requester.sv
module sim_tas_lock_requester;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ  = 3;
  localparam int DLY_W = 8;
  localparam int NVEC  = 5;

  typedef struct packed {
    logic [7:0] mn;
    logic [7:0] mx;
    logic [7:0] fails;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{mn: 8'd1, mx: 8'd8,   fails: 8'd5},
    '{mn: 8'd3, mx: 8'd20,  fails: 8'd4},
    '{mn: 8'd2, mx: 8'd2,   fails: 8'd3},
    '{mn: 8'd5, mx: 8'd255, fails: 8'd2},
    '{mn: 8'd1, mx: 8'd255, fails: 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREQ-1:0] acq = '0, rel = '0, granted, req_valid, req_ready, rsp_valid;
  logic [1:0] req_op [NREQ];
  logic [DLY_W-1:0] min_d = 8'd1, max_d = 8'd8;
  logic rsp_flag, rsp_tas, flag;
  logic steal_ld = 1'b0;
  int steal_req = 0, steal_left;
  int checks = 0, fails = 0, cyc = 0, excl_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    tas_lock_requester #(.DLY_W(DLY_W)) u0 (
      .clk(clk), .rst_n(rst_n), .acquire_i(acq[g]), .release_i(rel[g]),
      .granted_o(granted[g]), .min_delay_i(min_d), .max_delay_i(max_d),
      .lk_req_valid_o(req_valid[g]), .lk_req_ready_i(req_ready[g]),
      .lk_req_op_o(req_op[g]), .lk_rsp_valid_i(rsp_valid[g]), .lk_rsp_flag_i(rsp_flag)
    );
  end

  // Lock register model: one operation per cycle, lowest index wins.
  always_comb begin
    req_ready = '0;
    for (int i = 0; i < NREQ; i++)
      if (req_valid[i] && req_ready == '0) req_ready[i] = 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      flag <= 1'b0; rsp_valid <= '0; rsp_flag <= 1'b0; rsp_tas <= 1'b0; steal_left <= 0;
    end else begin
      rsp_valid <= '0;
      if (steal_ld) steal_left <= steal_req;
      for (int i = 0; i < NREQ; i++) begin
        if (req_ready[i]) begin
          case (req_op[i])
            2'd0: begin rsp_valid[i] <= 1'b1; rsp_flag <= flag; rsp_tas <= 1'b0; end
            2'd1: begin
              rsp_valid[i] <= 1'b1; rsp_tas <= 1'b1;
              if (steal_left > 0 && !steal_ld) begin
                rsp_flag <= 1'b1; steal_left <= steal_left - 1;
              end else begin
                rsp_flag <= flag; flag <= 1'b1;
              end
            end
            default: flag <= 1'b0;
          endcase
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && $countones(granted) > 1) excl_bad <= excl_bad + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(granted == '0 && req_valid == '0, "R1 during reset", {granted, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(granted == '0 && req_valid == '0, "R1 after reset", {granted, req_valid}, 0);

    // Table walk: forced failures on engine 0, timing of each pause.
    for (int v = 0; v < NVEC; v++) begin
      int dly, nf, fail_at, first_op;
      bit pend, seen_first, got;
      min_d = VECS[v].mn; max_d = VECS[v].mx;
      steal_req = int'(VECS[v].fails); steal_ld = 1'b1;
      @(negedge clk);
      steal_ld = 1'b0; acq[0] = 1'b1;
      dly = VECS[v].mn; nf = 0; pend = 0; seen_first = 0; got = 0; fail_at = 0; first_op = 0;
      for (int t = 0; t < 3000 && !got; t++) begin
        @(negedge clk);
        if (req_valid[0] && !seen_first) begin seen_first = 1; first_op = req_op[0]; end
        if (pend && req_valid[0]) begin
          chk(cyc - fail_at == dly + 1, (nf == 1) ? "R7 first pause" : "R5/R6 pause", cyc - fail_at, dly + 1);
          chk(req_op[0] == 2'd0, "R5 read after pause", req_op[0], 0);
          dly = (2 * dly > VECS[v].mx) ? int'(VECS[v].mx) : 2 * dly;
          pend = 0;
        end
        if (rsp_valid[0] && rsp_tas && rsp_flag) begin pend = 1; fail_at = cyc; nf++; end
        if (granted[0]) got = 1;
      end
      chk(first_op == 0, "R2 first op read", first_op, 0);
      chk(got && nf == int'(VECS[v].fails), "R4 grant after fails", nf, VECS[v].fails);
      acq[0] = 1'b0;
      repeat (4) @(negedge clk);
      chk(granted[0] == 1'b1, "R4 grant held", granted[0], 1);
      rel[0] = 1'b1;
      @(negedge clk);
      rel[0] = 1'b0;
      chk(req_valid[0] && req_op[0] == 2'd2 && !granted[0], "R9 clear request", req_op[0], 2);
      @(negedge clk);
      chk(!granted[0] && !req_valid[0], "R9 idle after clear", {granted[0], req_valid[0]}, 0);
    end

    // R3: engine 1 holds the lock, engine 0 must only poll with reads.
    min_d = 8'd1; max_d = 8'd4;
    acq[1] = 1'b1;
    while (!granted[1]) @(negedge clk);
    acq[1] = 1'b0;
    acq[0] = 1'b1;
    begin
      int bad = 0;
      for (int t = 0; t < 60; t++) begin
        @(negedge clk);
        if (granted[0] || (req_valid[0] && req_op[0] != 2'd0)) bad++;
      end
      chk(bad == 0, "R3 reads only while busy", bad, 0);
    end
    rel[1] = 1'b1; @(negedge clk); rel[1] = 1'b0;
    begin
      int t = 0;
      while (!granted[0] && t < 200) begin @(negedge clk); t++; end
      chk(granted[0], "R10 waiter acquires after release", granted[0], 1);
    end
    acq[0] = 1'b0;
    rel[0] = 1'b1; @(negedge clk); rel[0] = 1'b0;
    repeat (3) @(negedge clk);

    // R8/R10: all engines contend, each holds a few cycles.
    begin
      int hold [NREQ];
      bit served [NREQ];
      bit stall [NREQ];
      logic [1:0] stall_op [NREQ];
      int bp_bad = 0, bp_seen = 0;
      for (int i = 0; i < NREQ; i++) begin hold[i] = 0; served[i] = 0; stall[i] = 0; stall_op[i] = 0; end
      acq = '1;
      for (int t = 0; t < 4000; t++) begin
        @(negedge clk);
        rel = '0;
        for (int i = 0; i < NREQ; i++) begin
          if (stall[i]) begin
            bp_seen++;
            if (!req_valid[i] || req_op[i] != stall_op[i]) bp_bad++;
          end
          stall[i] = req_valid[i] && !req_ready[i];
          stall_op[i] = req_op[i];
          if (granted[i]) begin
            acq[i] = 1'b0; served[i] = 1; hold[i]++;
            if (hold[i] == 5) rel[i] = 1'b1;
          end
        end
      end
      rel = '0;
      chk(bp_seen > 0 && bp_bad == 0, "R8 request stable under back-pressure", bp_bad, 0);
      for (int i = 0; i < NREQ; i++)
        chk(served[i], "R10 every engine served", served[i], 1);
    end
    chk(excl_bad == 0, "R10 mutual exclusion", excl_bad, 0);
    finish_run();
  end
endmodule